// File: doc/BRIEF.md
# Per-Vector Interrupt Table Controller

This block delivers message-style interrupts from a set of vectors, each with its own 64-bit target address, 32-bit payload and mask bit, all kept in a table that software programs through a simple register port. Function logic raises one-cycle pulses per vector. When a vector may deliver, the block issues a posted write carrying that entry's address and data through a valid/ready handshake. When it may not deliver, the block records the event in a hardware-owned pending array and replays it once the vector becomes deliverable again.

Two mask layers gate delivery: a function-wide mask held with the enable bit in a control word, and a mask bit in each entry. A synchronous function reset returns the whole block to its reset state and drops every pending event, so nothing is delivered afterwards. The register port reads combinationally and writes on the clock edge. Only word-aligned addresses decode.

Top module: `irq_vec_table`

## Requirements
- R1: After reset, every entry has address and data zero and its mask bit set, the enable and function mask are clear, every pending bit reads 0 and wrValid is low.
- R2: Entry v sits at byte offset v*16. Word +0x0 holds the lower address, +0x4 the upper address, +0x8 the data, and bit 0 of +0xC is the entry mask (1 = masked). All four words read back as written (the mask word reads as zero apart from bit 0).
- R3: The control word at CTRL_OFF has the enable in bit 15 and the function mask in bit 14, both read-write. Bits 10:0 read NUM_VEC-1 and are read-only.
- R4: A pulse on a vector that is enabled and unmasked at both levels raises wrValid two clock edges after the pulse is sampled. wrAddr is {upper, lower} and wrData is the entry data. wrValid stays high until wrReady is seen.
- R5: A pulse on a vector that is masked at either level sends no write and sets that vector's bit in the pending array (bit v of the word at PBA_OFF).
- R6: When a pending vector becomes deliverable, its write is issued and its pending bit reads 0 from the cycle wrValid rises.
- R7: Setting or clearing the function mask leaves the entry masks unchanged. Clearing it replays only the pending vectors whose own mask is clear, lowest index first, one per handshake, with the next write presented in the cycle after the previous one is accepted.
- R8: Software writes to the pending array have no effect.
- R9: A pulse on a vector that is already pending merges with it, so only one write results.
- R10: If either mask is set while a write is presented and has not yet been accepted, wrValid drops, the vector's pending bit is set, and the write is replayed once the vector is unmasked.
- R11: While the enable bit is clear, pulses are ignored, no write is presented and the pending bits keep their values. Setting the enable again replays deliverable pending vectors.
- R12: A one-cycle flrReset clears the pending array, the table, the enable and the function mask, and no write follows it.
- R13: The address and data of a write are captured when it is issued. Changing the entry while wrValid is held does not change wrAddr or wrData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flrReset | input | 1 | Synchronous function reset, one cycle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| irqPulse | input | NUM_VEC | Per-vector interrupt pulses |
| wrValid | output | 1 | Posted write presented |
| wrReady | input | 1 | Posted write accepted when high with wrValid |
| wrAddr | output | 64 | Write target address |
| wrData | output | 32 | Write payload |

## Verification
The hardest situation to reach is a write withdrawn mid-handshake: a vector must be issued, held with wrReady low, and then masked by a register write before acceptance. The bench reaches it by replaying a pending vector, keeping wrReady low, and writing that entry's mask word, then reading the pending array back before unmasking again. A second hard case is the function mask being cleared with several vectors pending and one of them still masked by its own entry. The bench gathers the events in one multi-bit pulse and then walks the accept-by-accept replay order.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int MAX_VEC_W = 11;

  // control -> datapath: capture the payload of the vector being issued
  typedef struct packed {
    logic                 load;
    logic [MAX_VEC_W-1:0] vec;
  } issue_strobe_t;

  localparam logic [1:0] WORD_ADDR_LO = 2'd0;
  localparam logic [1:0] WORD_ADDR_HI = 2'd1;
  localparam logic [1:0] WORD_DATA    = 2'd2;
  localparam logic [1:0] WORD_VCTRL   = 2'd3;
  localparam int EN_BIT    = 15;
  localparam int FMASK_BIT = 14;
endpackage

// File: rtl/irq_vec_dpath.sv
module irq_vec_dpath
  import irq_vec_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int VEC_W    = 3,
  parameter int ADDR_W   = 12,
  parameter int PBA_OFF  = 256,
  parameter int CTRL_OFF = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flrReset,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_VEC-1:0] pendBits,
  input  issue_strobe_t      strobe,
  output logic               enBit,
  output logic               fmaskBit,
  output logic [NUM_VEC-1:0] maskBits,
  output logic [63:0]        wrAddr,
  output logic [31:0]        wrData
);
  localparam int PBA_WORDS = (NUM_VEC + 31) / 32;
  localparam logic [ADDR_W-1:0] TABLE_END = ADDR_W'(NUM_VEC * 16);
  localparam logic [ADDR_W-1:0] PBA_BASE  = ADDR_W'(PBA_OFF);
  localparam logic [ADDR_W-1:0] PBA_END   = ADDR_W'(PBA_OFF + 4 * PBA_WORDS);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFF);

  logic              aligned, tableHit, pbaHit, ctrlHit;
  logic [VEC_W-1:0]  entryIdx;
  logic [1:0]        wordSel;
  logic [ADDR_W-1:0] pbaRel;
  logic [PBA_WORDS*32-1:0] pendPad;
  logic [NUM_VEC-1:0][31:0] loAll, hiAll, dataAll;

  assign aligned  = (regAddr[1:0] == 2'b00);
  assign tableHit = aligned && (regAddr < TABLE_END);
  assign pbaHit   = aligned && (regAddr >= PBA_BASE) && (regAddr < PBA_END);
  assign ctrlHit  = aligned && (regAddr == CTRL_ADDR);
  assign entryIdx = regAddr[VEC_W+3:4];
  assign wordSel  = regAddr[3:2];
  assign pbaRel   = regAddr - PBA_BASE;
  assign pendPad  = (PBA_WORDS*32)'(pendBits);

  // one storage slice per entry
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
    logic [31:0] lo, hi, dat;
    logic        msk;
    logic        hit;
    assign hit = regWrEn && tableHit && (entryIdx == VEC_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo <= '0; hi <= '0; dat <= '0; msk <= 1'b1;
      end else if (flrReset) begin
        lo <= '0; hi <= '0; dat <= '0; msk <= 1'b1;
      end else if (hit) begin
        case (wordSel)
          WORD_ADDR_LO: lo  <= regWrData;
          WORD_ADDR_HI: hi  <= regWrData;
          WORD_DATA:    dat <= regWrData;
          default:      msk <= regWrData[0];
        endcase
      end
    end
    assign loAll[g]   = lo;
    assign hiAll[g]   = hi;
    assign dataAll[g] = dat;
    assign maskBits[g] = msk;
  end

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enBit <= 1'b0; fmaskBit <= 1'b0;
    end else if (flrReset) begin
      enBit <= 1'b0; fmaskBit <= 1'b0;
    end else if (regWrEn && ctrlHit) begin
      enBit    <= regWrData[EN_BIT];
      fmaskBit <= regWrData[FMASK_BIT];
    end
  end

  // payload capture at issue
  logic [63:0] selAddr;
  logic [31:0] selData;
  always_comb begin
    selAddr = '0;
    selData = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (strobe.vec == MAX_VEC_W'(i)) begin
        selAddr = {hiAll[i], loAll[i]};
        selData = dataAll[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrAddr <= '0; wrData <= '0;
    end else if (strobe.load) begin
      wrAddr <= selAddr; wrData <= selData;
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (tableHit) begin
      case (wordSel)
        WORD_ADDR_LO: regRdData = loAll[entryIdx];
        WORD_ADDR_HI: regRdData = hiAll[entryIdx];
        WORD_DATA:    regRdData = dataAll[entryIdx];
        default:      regRdData = {31'b0, maskBits[entryIdx]};
      endcase
    end else if (pbaHit) begin
      for (int w = 0; w < PBA_WORDS; w++)
        if (pbaRel[ADDR_W-1:2] == (ADDR_W-2)'(w)) regRdData = pendPad[w*32 +: 32];
    end else if (ctrlHit) begin
      regRdData[EN_BIT]    = enBit;
      regRdData[FMASK_BIT] = fmaskBit;
      regRdData[10:0]      = 11'(NUM_VEC - 1);
    end
  end

  // R3: a control write lands in the enable bit on the next cycle
  p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && ctrlHit && !flrReset) |=> (enBit == $past(regWrData[EN_BIT])));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flrReset,
  input  logic [NUM_VEC-1:0] irqPulse,
  input  logic               enBit,
  input  logic               fmaskBit,
  input  logic [NUM_VEC-1:0] maskBits,
  input  logic               wrReady,
  output logic               wrValid,
  output logic [NUM_VEC-1:0] pendBits,
  output issue_strobe_t      strobe
);
  logic [NUM_VEC-1:0] pendQ, pendNext, okVec, candidates, newEvents;
  logic               busyQ, busyNext;
  logic [VEC_W-1:0]   curQ, curNext, pick;
  logic               curOk, accept, withdraw, freeSlot, issue;

  assign okVec      = (enBit && !fmaskBit) ? ~maskBits : '0;
  assign curOk      = okVec[curQ];
  assign wrValid    = busyQ && curOk;
  assign accept     = wrValid && wrReady;
  assign withdraw   = busyQ && !curOk;
  assign freeSlot   = !busyQ || accept;
  assign candidates = pendQ & okVec;
  assign issue      = freeSlot && (|candidates);
  assign newEvents  = enBit ? irqPulse : '0;
  assign pendBits   = pendQ;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (candidates[i]) pick = VEC_W'(i);
  end

  always_comb begin
    pendNext = pendQ | newEvents;
    busyNext = busyQ;
    curNext  = curQ;
    if (withdraw) begin
      pendNext[curQ] = 1'b1;
      busyNext       = 1'b0;
    end else if (accept) begin
      busyNext = 1'b0;
    end
    if (issue) begin
      pendNext[pick] = 1'b0;
      busyNext       = 1'b1;
      curNext        = pick;
    end
  end

  assign strobe.load = issue;
  assign strobe.vec  = MAX_VEC_W'(pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= '0; busyQ <= 1'b0; curQ <= '0;
    end else if (flrReset) begin
      pendQ <= '0; busyQ <= 1'b0; curQ <= '0;
    end else begin
      pendQ <= pendNext; busyQ <= busyNext; curQ <= curNext;
    end
  end

  // R5: a pulse on a blocked vector leaves its pending bit set
  p_blocked_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enBit && !flrReset && |(irqPulse & ~okVec)) |=> |(pendQ & $past(irqPulse & ~okVec)));

  // R12: function reset leaves nothing pending and nothing presented
  p_flr_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flrReset |=> (pendQ == '0 && !wrValid));

  // R11: disabled and idle keeps the pending array frozen
  p_disabled_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enBit && !busyQ && !flrReset) |=> (pendQ == $past(pendQ)));
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table
  import irq_vec_pkg::*;
#(
  parameter int NUM_VEC  = 8,
  parameter int ADDR_W   = 12,
  parameter int PBA_OFF  = 256,
  parameter int CTRL_OFF = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flrReset,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_VEC-1:0] irqPulse,
  output logic               wrValid,
  input  logic               wrReady,
  output logic [63:0]        wrAddr,
  output logic [31:0]        wrData
);
  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic               enBit, fmaskBit;
  logic [NUM_VEC-1:0] maskBits, pendBits;
  issue_strobe_t      strobe;

  irq_vec_ctrl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flrReset(flrReset), .irqPulse(irqPulse),
    .enBit(enBit), .fmaskBit(fmaskBit), .maskBits(maskBits),
    .wrReady(wrReady), .wrValid(wrValid), .pendBits(pendBits), .strobe(strobe)
  );

  irq_vec_dpath #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
                  .PBA_OFF(PBA_OFF), .CTRL_OFF(CTRL_OFF)) u_dpath (
    .clk(clk), .rst_n(rst_n), .flrReset(flrReset), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pendBits(pendBits), .strobe(strobe), .enBit(enBit), .fmaskBit(fmaskBit),
    .maskBits(maskBits), .wrAddr(wrAddr), .wrData(wrData)
  );

  // R13: payload held steady while a write waits for acceptance
  p_payload_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrReady) |=> (!wrValid || ($stable(wrAddr) && $stable(wrData))));
endmodule

// File: tb/irq_vec_table_bench.sv
module irq_vec_table_bench;
  localparam int NV = 8;
  localparam logic [11:0] PBA  = 12'h100;
  localparam logic [11:0] CTRL = 12'h200;

  logic clk = 1'b0, rst_n = 1'b0, flrReset = 1'b0, regWrEn = 1'b0, wrReady = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData, wrData;
  logic [NV-1:0] irqPulse = '0;
  logic wrValid;
  logic [63:0] wrAddr;
  int nChecks = 0, nFails = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  irq_vec_table u_irq_vec_table (
    .clk(clk), .rst_n(rst_n), .flrReset(flrReset), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqPulse(irqPulse), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  typedef struct packed {
    logic [2:0]  vec;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] dat;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{3'd0, 32'hFEE0_0000, 32'h0000_0000, 32'h0000_0040},
    '{3'd3, 32'hFEE0_3000, 32'h0000_0001, 32'h0000_0043},
    '{3'd5, 32'hFEE0_5004, 32'hABCD_0002, 32'h1234_5645},
    '{3'd7, 32'hFEE0_7008, 32'h0000_0003, 32'hCAFE_0047}
  };

  function automatic logic [11:0] ent(input int v, input int w);
    return 12'(v * 16 + w * 4);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    irqPulse = m;
    tick();
    irqPulse = '0;
  endtask

  task automatic accept();
    wrReady = 1'b1;
    tick();
    wrReady = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 / R3 reset state
    rdReg(CTRL, rd);       chk("R1 R3 ctrl reset", rd, 32'h7);
    rdReg(ent(2, 3), rd);  chk("R1 entry mask reset", rd, 32'h1);
    rdReg(ent(2, 0), rd);  chk("R1 entry addr reset", rd, 0);
    rdReg(PBA, rd);        chk("R1 pending reset", rd, 0);
    chk("R1 valid reset", wrValid, 0);

    // R3 control readback, size field read-only
    wr(CTRL, 32'hC7FF);
    rdReg(CTRL, rd);       chk("R3 ctrl rw", rd, 32'hC007);
    wr(CTRL, 32'h8000);

    // R2 table readback
    wr(ent(6, 0), 32'h1111_2220); wr(ent(6, 1), 32'h3333_4444); wr(ent(6, 2), 32'h5555_6666);
    rdReg(ent(6, 0), rd); chk("R2 lo", rd, 32'h1111_2220);
    rdReg(ent(6, 1), rd); chk("R2 hi", rd, 32'h3333_4444);
    rdReg(ent(6, 2), rd); chk("R2 data", rd, 32'h5555_6666);

    // R4 vector table walk
    foreach (ROWS[i]) begin
      wr(ent(ROWS[i].vec, 0), ROWS[i].lo);
      wr(ent(ROWS[i].vec, 1), ROWS[i].hi);
      wr(ent(ROWS[i].vec, 2), ROWS[i].dat);
      wr(ent(ROWS[i].vec, 3), 0);
      pulse(NV'(1) << ROWS[i].vec);
      chk("R4 not yet valid", wrValid, 0);
      tick();
      chk("R4 valid", wrValid, 1);
      chk("R4 addr", wrAddr, {ROWS[i].hi, ROWS[i].lo});
      chk("R4 data", wrData, ROWS[i].dat);
      tick();
      chk("R4 held", wrValid, 1);
      accept();
      chk("R4 released", wrValid, 0);
    end

    // R5 masked entry pends
    pulse(8'h40); tick(); tick();
    chk("R5 no write", wrValid, 0);
    rdReg(PBA, rd); chk("R5 pending", rd, 32'h40);
    // R8 pending array is read-only
    wr(PBA, 32'h0); wr(PBA, 32'hFF);
    rdReg(PBA, rd); chk("R8 pba ro", rd, 32'h40);
    // R9 merge
    pulse(8'h40); tick();
    rdReg(PBA, rd); chk("R9 merged pending", rd, 32'h40);
    // R6 unmask replays
    wr(ent(6, 3), 0); tick();
    chk("R6 valid", wrValid, 1);
    chk("R6 addr", wrAddr, 64'h3333_4444_1111_2220);
    rdReg(PBA, rd); chk("R6 pending cleared", rd, 0);
    accept(); tick(); tick();
    chk("R9 single write", wrValid, 0);

    // R7 function mask
    wr(CTRL, 32'hC000);
    wr(ent(3, 3), 1);
    pulse(8'h29); tick();
    chk("R7 fmask no write", wrValid, 0);
    rdReg(PBA, rd); chk("R7 pending", rd, 32'h29);
    rdReg(ent(5, 3), rd); chk("R7 entry mask kept", rd, 0);
    wr(CTRL, 32'h8000); tick();
    chk("R7 first valid", wrValid, 1);
    chk("R7 lowest first", wrAddr, {ROWS[0].hi, ROWS[0].lo});
    accept();
    chk("R7 back to back", wrValid, 1);
    chk("R7 second vec", wrAddr, {ROWS[2].hi, ROWS[2].lo});
    accept();
    chk("R7 entry-masked stays", wrValid, 0);
    rdReg(PBA, rd); chk("R7 vec3 still pending", rd, 32'h08);

    // R10 withdrawal
    wr(ent(3, 3), 0); tick();
    chk("R10 issued", wrValid, 1);
    wr(ent(3, 3), 1);
    chk("R10 withdrawn", wrValid, 0);
    tick();
    rdReg(PBA, rd); chk("R10 re-pended", rd, 32'h08);
    wr(ent(3, 3), 0); tick();
    chk("R10 replay", wrAddr, {ROWS[1].hi, ROWS[1].lo});
    chk("R10 replay valid", wrValid, 1);
    accept();

    // R13 payload captured at issue
    pulse(8'h80); tick();
    chk("R13 valid", wrValid, 1);
    wr(ent(7, 2), 32'hDEAD_BEEF);
    chk("R13 data kept", wrData, ROWS[3].dat);
    accept();
    rdReg(ent(7, 2), rd); chk("R2 data update", rd, 32'hDEAD_BEEF);

    // R11 enable clear
    wr(ent(5, 3), 1);
    pulse(8'h20); tick();
    rdReg(PBA, rd); chk("R5 pend vec5", rd, 32'h20);
    wr(CTRL, 32'h0);
    pulse(8'h21); tick();
    chk("R11 no write", wrValid, 0);
    rdReg(PBA, rd); chk("R11 pending unchanged", rd, 32'h20);
    wr(ent(5, 3), 0); tick();
    chk("R11 disabled no replay", wrValid, 0);
    wr(CTRL, 32'h8000); tick();
    chk("R11 replay on enable", wrValid, 1);
    chk("R11 replay addr", wrAddr, {ROWS[2].hi, ROWS[2].lo});
    accept();

    // R12 function reset
    wr(ent(0, 3), 1);
    pulse(8'h01); tick();
    rdReg(PBA, rd); chk("R12 pre pending", rd, 32'h01);
    flrReset = 1'b1; tick(); flrReset = 1'b0;
    rdReg(PBA, rd); chk("R12 pending cleared", rd, 0);
    rdReg(CTRL, rd); chk("R12 ctrl cleared", rd, 32'h7);
    rdReg(ent(0, 3), rd); chk("R12 entry masked", rd, 1);
    wr(CTRL, 32'h8000); wr(ent(0, 3), 0);
    for (int k = 0; k < 4; k++) begin
      chk("R12 no write after reset", wrValid, 0);
      tick();
    end

    summary();
    $finish;
  end
endmodule